// File: doc/BRIEF.md
# Serial-Read Event and Status Flag Register

This block holds eight status flags for a low-speed USB device bridge. A host microcontroller reads them over a serial link. The flags record bus events: a hardware reset, a USB reset, any bus activity, a resume, IN completion on two endpoint groups, and OUT completion. The lowest flag mirrors a wake pin.

Each flag has its own set rule and its own clear rule. Some flags clear when the register is read. Others clear on an edge of the serial-select input. The two reset flags can also clear each other. A read is a falling edge on the serial data input while serial-select is low. On that edge the register value is copied into the shift byte, which is the first byte sent to the host, and the read-clear flags are then cleared.

The block also produces three side outputs:
- a one-cycle pulse that re-enables endpoint 0 when the USB-reset flag clears;
- a level that clears the two suspend bits of the bridge configuration while activity or resume is flagged;
- an active-low interrupt that presents the wake flag while select is high.

The transceiver and endpoint logic are modelled as synchronous strobes and levels. The wake pin, select and serial data are asynchronous and pass through synchronizers.

Top module: `statusFlagReg`

## Requirements
- R1: After the hardware reset, with the wake pin low, `statusByte` reads 8'h81 and `shiftByte` reads 8'h00. `cfgClear` is 0 and `wakeIntN` is 1.
- R2: When the synchronized select is low, a falling edge of the synchronized serial data copies `statusByte` into `shiftByte`. The same edge while select is high leaves `shiftByte` unchanged.
- R3: Only the hardware reset sets bit 7. A read clears it. The onset of a USB reset (`usbResetLvl` rising) also clears it.
- R4: Bit 6 is 1 in the cycle after any cycle in which `usbResetLvl` is high. It then stays 1 until a read clears it. The hardware reset also clears it.
- R5: `ep0EnPulse` is high for exactly one cycle each time bit 6 goes from 1 to 0. That cycle is the first cycle in which bit 6 reads 0.
- R6: `busActive` sets bit 5 and a read clears it. If a set and a read-clear fall on the same edge, the bit ends up 1.
- R7: Bit 4 follows `resumeLvl` with one cycle of delay.
- R8: `cfgClear` is 1 exactly while bit 5 or bit 4 is 1.
- R9: `inDoneEp12` sets bit 3 and `inDoneEp0` sets bit 2. Both bits clear only on a falling edge of select.
- R10: `outDone` sets bit 1. Bit 1 clears only on a rising edge of select.
- R11: Bit 0 is the inverse of the synchronized wake pin. `wakeIntN` equals bit 0 while the synchronized select is high, and is 1 otherwise.
- R12: A read-clear takes effect only after the capture. `shiftByte` holds the pre-clear value, and `statusByte` shows the cleared value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hardware reset (all hardware sources combined) |
| wakePin | input | 1 | Asynchronous wake pin level |
| serSelect | input | 1 | Asynchronous serial select |
| serData | input | 1 | Asynchronous serial data input; a falling edge while select is low is a read |
| usbResetLvl | input | 1 | High while a USB reset is on the bus |
| busActive | input | 1 | High while the bus is in any state other than idle |
| resumeLvl | input | 1 | High while a resume is being decoded |
| inDoneEp12 | input | 1 | One-cycle strobe: IN transfer on endpoints 1/2 completed with ACK |
| inDoneEp0 | input | 1 | One-cycle strobe: IN transfer on endpoint 0 completed with ACK |
| outDone | input | 1 | One-cycle strobe: OUT/SETUP data complete and ACK sent |
| statusByte | output | 8 | Current flag register |
| shiftByte | output | 8 | Value captured at the last read |
| ep0EnPulse | output | 1 | Enable pulse for the endpoint 0 OUT and IN flags |
| cfgClear | output | 1 | Clear request for the suspend-output and controller-suspend bits |
| wakeIntN | output | 1 | Active-low wake interrupt, valid while select is high |

## Verification
The hardest case to reach is a set event that lands on the same clock edge as a read-clear. The read is seen only after the serial data passes the synchronizer and the edge detector. The bench therefore drops serial data away from the clock and counts two rising edges. It then raises `busActive` for the single cycle whose closing edge also applies the read-clear. It checks that the captured byte lacks the activity flag and that the register still holds it. The cross-clear of the two reset flags, and the single-cycle width of the endpoint 0 enable pulse, are checked with a pulse counter that runs through the whole read sequence.

// File: rtl/statusFlagPkg.sv
package statusFlagPkg;

  localparam int STATUS_W = 8;

  // Bit positions; the host decodes the byte, so these are fixed.
  localparam int BIT_HWRST  = 7;
  localparam int BIT_USBRST = 6;
  localparam int BIT_ACT    = 5;
  localparam int BIT_RESUME = 4;
  localparam int BIT_IN12   = 3;
  localparam int BIT_IN0    = 2;
  localparam int BIT_OUT    = 1;
  localparam int BIT_WAKE   = 0;

  typedef struct packed {
    logic loadNow;     // read: capture and read-clear on this edge
    logic selRise;
    logic selFall;
    logic usbRstRise;
    logic selLevel;
    logic wakeLevel;
  } ctrlStrobes_t;

endpackage

// File: rtl/statusFlagCtrl.sv
module statusFlagCtrl
  import statusFlagPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakePin,
  input  logic         serSelect,
  input  logic         serData,
  input  logic         usbResetLvl,
  output ctrlStrobes_t str
);

  localparam int N_ASYNC = 3;
  localparam int IDX_WAKE = 0;
  localparam int IDX_SEL  = 1;
  localparam int IDX_SDI  = 2;

  logic [N_ASYNC-1:0] asyncIn;
  logic [N_ASYNC-1:0] syncOut;

  assign asyncIn = {serData, serSelect, wakePin};

  genvar g;
  for (g = 0; g < N_ASYNC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '0;
      else       stage <= {stage[SYNC_STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = stage[SYNC_STAGES-1];
  end

  logic selPrev;
  logic sdiPrev;
  logic usbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 1'b0;
      sdiPrev <= 1'b0;
      usbPrev <= 1'b0;
    end else begin
      selPrev <= syncOut[IDX_SEL];
      sdiPrev <= syncOut[IDX_SDI];
      usbPrev <= usbResetLvl;
    end
  end

  always_comb begin
    str.selLevel   = syncOut[IDX_SEL];
    str.wakeLevel  = syncOut[IDX_WAKE];
    str.selRise    = syncOut[IDX_SEL] & ~selPrev;
    str.selFall    = ~syncOut[IDX_SEL] & selPrev;
    str.loadNow    = sdiPrev & ~syncOut[IDX_SDI] & ~syncOut[IDX_SEL];
    str.usbRstRise = usbResetLvl & ~usbPrev;
  end

  // R2: a read is recognised only while select is low.
  a_r2_load_needs_sel_low: assert property (@(posedge clk) disable iff (!rstN)
    str.loadNow |-> !str.selLevel);

endmodule

// File: rtl/statusFlagData.sv
module statusFlagData
  import statusFlagPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        str,
  input  logic                usbResetLvl,
  input  logic                busActive,
  input  logic                resumeLvl,
  input  logic                inDoneEp12,
  input  logic                inDoneEp0,
  input  logic                outDone,
  output logic [STATUS_W-1:0] statusByte,
  output logic [STATUS_W-1:0] shiftByte,
  output logic                ep0EnPulse,
  output logic                cfgClear,
  output logic                wakeIntN
);

  logic hwRstF, usbRstF, actF, resF, in12F, in0F, outF;
  logic usbRstNext;

  assign usbRstNext = usbResetLvl | (usbRstF & ~str.loadNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwRstF     <= 1'b1;
      usbRstF    <= 1'b0;
      actF       <= 1'b0;
      resF       <= 1'b0;
      in12F      <= 1'b0;
      in0F       <= 1'b0;
      outF       <= 1'b0;
      shiftByte  <= '0;
      ep0EnPulse <= 1'b0;
    end else begin
      // R12: capture uses the value before this edge's clears.
      if (str.loadNow) shiftByte <= statusByte;
      hwRstF     <= hwRstF & ~str.loadNow & ~str.usbRstRise;
      usbRstF    <= usbRstNext;
      ep0EnPulse <= usbRstF & ~usbRstNext;
      actF       <= busActive | (actF & ~str.loadNow);
      resF       <= resumeLvl;
      in12F      <= inDoneEp12 | (in12F & ~str.selFall);
      in0F       <= inDoneEp0  | (in0F  & ~str.selFall);
      outF       <= outDone    | (outF  & ~str.selRise);
    end
  end

  always_comb begin
    statusByte             = '0;
    statusByte[BIT_HWRST]  = hwRstF;
    statusByte[BIT_USBRST] = usbRstF;
    statusByte[BIT_ACT]    = actF;
    statusByte[BIT_RESUME] = resF;
    statusByte[BIT_IN12]   = in12F;
    statusByte[BIT_IN0]    = in0F;
    statusByte[BIT_OUT]    = outF;
    statusByte[BIT_WAKE]   = ~str.wakeLevel;
  end

  assign cfgClear = actF | resF;
  assign wakeIntN = str.selLevel ? statusByte[BIT_WAKE] : 1'b1;

  a_r3_hwrst_never_sets: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[BIT_HWRST] |=> !statusByte[BIT_HWRST]);

  a_r4_usbrst_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    usbResetLvl |=> statusByte[BIT_USBRST]);

  a_r5_pulse_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    ep0EnPulse |-> (!statusByte[BIT_USBRST] && $past(statusByte[BIT_USBRST])));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    busActive |=> statusByte[BIT_ACT]);

  a_r9_in_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[BIT_IN12] && !str.selFall) |=> statusByte[BIT_IN12]);

  a_r10_out_sets: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> statusByte[BIT_OUT]);

endmodule

// File: rtl/statusFlagReg.sv
module statusFlagReg
  import statusFlagPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakePin,
  input  logic       serSelect,
  input  logic       serData,
  input  logic       usbResetLvl,
  input  logic       busActive,
  input  logic       resumeLvl,
  input  logic       inDoneEp12,
  input  logic       inDoneEp0,
  input  logic       outDone,
  output logic [7:0] statusByte,
  output logic [7:0] shiftByte,
  output logic       ep0EnPulse,
  output logic       cfgClear,
  output logic       wakeIntN
);

  ctrlStrobes_t str;

  statusFlagCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wakePin    (wakePin),
    .serSelect  (serSelect),
    .serData    (serData),
    .usbResetLvl(usbResetLvl),
    .str        (str)
  );

  statusFlagData i_data (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .usbResetLvl(usbResetLvl),
    .busActive  (busActive),
    .resumeLvl  (resumeLvl),
    .inDoneEp12 (inDoneEp12),
    .inDoneEp0  (inDoneEp0),
    .outDone    (outDone),
    .statusByte (statusByte),
    .shiftByte  (shiftByte),
    .ep0EnPulse (ep0EnPulse),
    .cfgClear   (cfgClear),
    .wakeIntN   (wakeIntN)
  );

endmodule

// File: tb/test_statusFlagReg.sv
`timescale 1ns/100ps
module test_statusFlagReg;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakePin = 1'b0, serSelect = 1'b0, serData = 1'b0;
  logic usbResetLvl = 1'b0, busActive = 1'b0, resumeLvl = 1'b0;
  logic inDoneEp12 = 1'b0, inDoneEp0 = 1'b0, outDone = 1'b0;
  logic [7:0] statusByte, shiftByte;
  logic ep0EnPulse, cfgClear, wakeIntN;

  int nChecks = 0;
  int nFails  = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  statusFlagReg i_statusFlagReg (
    .clk(clk), .rstN(rstN), .wakePin(wakePin), .serSelect(serSelect),
    .serData(serData), .usbResetLvl(usbResetLvl), .busActive(busActive),
    .resumeLvl(resumeLvl), .inDoneEp12(inDoneEp12), .inDoneEp0(inDoneEp0),
    .outDone(outDone), .statusByte(statusByte), .shiftByte(shiftByte),
    .ep0EnPulse(ep0EnPulse), .cfgClear(cfgClear), .wakeIntN(wakeIntN)
  );

  always @(posedge clk) if (ep0EnPulse) pulseCnt++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic hwReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    settle();
  endtask

  task automatic readOut();
    @(negedge clk) serData = 1'b1;
    settle();
    serData = 1'b0;
    settle();
  endtask

  task automatic pulseActive();
    @(negedge clk) busActive = 1'b1;
    @(negedge clk) busActive = 1'b0;
    settle();
  endtask

  initial begin
    #(5 * 50000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int snap;
    logic [7:0] pre;
    hwReset();
    // R1 reset state
    chk("R1 status", statusByte, 8'h81);
    chk("R1 shift", shiftByte, 8'h00);
    chk("R1 cfgClear", {7'd0, cfgClear}, 8'h00);
    chk("R1 wakeIntN", {7'd0, wakeIntN}, 8'h01);

    // R2/R3/R12 first read
    readOut();
    chk("R2 R12 captured", shiftByte, 8'h81);
    chk("R3 read clears bit7", statusByte, 8'h01);

    // R6/R8 activity sticky, cleared by read
    pulseActive();
    chk("R6 activity set", statusByte, 8'h21);
    chk("R8 cfgClear on activity", {7'd0, cfgClear}, 8'h01);
    readOut();
    chk("R12 activity captured", shiftByte, 8'h21);
    chk("R6 read clears activity", statusByte, 8'h01);
    chk("R8 cfgClear released", {7'd0, cfgClear}, 8'h00);

    // R6 set wins over read-clear on the same edge
    @(negedge clk) serData = 1'b1;
    settle();
    serData = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) busActive = 1'b1;
    @(negedge clk) busActive = 1'b0;
    settle();
    chk("R6 same-edge capture", shiftByte, 8'h01);
    chk("R6 set wins", statusByte, 8'h21);
    readOut();
    chk("R6 later read clears", statusByte, 8'h01);

    // R7/R8 resume follows
    @(negedge clk) resumeLvl = 1'b1;
    settle();
    chk("R7 resume set", statusByte, 8'h11);
    chk("R8 cfgClear on resume", {7'd0, cfgClear}, 8'h01);
    @(negedge clk) resumeLvl = 1'b0;
    settle();
    chk("R7 resume clear", statusByte, 8'h01);
    chk("R8 cfgClear off", {7'd0, cfgClear}, 8'h00);

    // R3/R4 cross-clear by USB reset onset
    hwReset();
    chk("R1 again", statusByte, 8'h81);
    @(negedge clk) usbResetLvl = 1'b1;
    settle();
    chk("R3 R4 usb reset clears bit7", statusByte, 8'h41);
    readOut();
    chk("R4 level holds through read", statusByte, 8'h41);
    @(negedge clk) usbResetLvl = 1'b0;
    settle();
    chk("R4 sticky after level", statusByte, 8'h41);
    snap = pulseCnt;
    readOut();
    chk("R4 read clears bit6", statusByte, 8'h01);
    settle();
    chk("R5 one pulse", 8'(pulseCnt - snap), 8'd1);

    // R4 hardware reset clears bit6
    @(negedge clk) usbResetLvl = 1'b1;
    @(negedge clk) usbResetLvl = 1'b0;
    settle();
    chk("R4 set again", statusByte, 8'h41);
    snap = pulseCnt;
    hwReset();
    chk("R4 hw reset clears bit6", statusByte, 8'h81);
    chk("R5 no pulse on hw reset", 8'(pulseCnt - snap), 8'd0);

    // R9/R10/R11 sweep of completion strobes and wake
    for (int p = 0; p < 8; p++) begin
      logic w;
      w = p[0] ^ p[2];
      @(negedge clk);
      wakePin = w;
      inDoneEp12 = p[2];
      inDoneEp0  = p[1];
      outDone    = p[0];
      @(negedge clk);
      inDoneEp12 = 1'b0; inDoneEp0 = 1'b0; outDone = 1'b0;
      settle();
      chk("R9 R10 R11 set", {4'd0, statusByte[3:0]}, {4'd0, p[2], p[1], p[0], ~w});
      chk("R11 wakeIntN sel low", {7'd0, wakeIntN}, 8'h01);
      serSelect = 1'b1;
      settle();
      chk("R10 sel rise clears only out", {4'd0, statusByte[3:0]}, {4'd0, p[2], p[1], 1'b0, ~w});
      chk("R11 wakeIntN sel high", {7'd0, wakeIntN}, {7'd0, ~w});
      serSelect = 1'b0;
      settle();
      chk("R9 sel fall clears in", {4'd0, statusByte[3:0]}, {4'd0, 3'b000, ~w});
    end

    // R10 a falling select does not clear bit1
    @(negedge clk) wakePin = 1'b0; serSelect = 1'b1;
    settle();
    @(negedge clk) outDone = 1'b1;
    @(negedge clk) outDone = 1'b0;
    serSelect = 1'b0;
    settle();
    chk("R10 sel fall keeps out", {6'd0, statusByte[1:0]}, 8'h03);

    // R2 no capture while select high
    pre = shiftByte;
    serSelect = 1'b1;
    settle();
    readOut();
    chk("R2 no load sel high", shiftByte, pre);
    serSelect = 1'b0;
    settle();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule